// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer. It counts system clock cycles and pulses a reset request when software fails to service it within a chosen timeout. Software services it by writing two key values in order to a service register. A single write never restarts the count, so a runaway loop that writes one value again and again cannot keep the timer quiet.

A control register is written once after reset. It sets the enable, picks whether the count advances on every clock or only on the output of a fixed prescaler, and selects one of four power-of-two timeouts. Both registers share a simple write port made of an address, a data byte and a strobe. The reset request output goes to an external reset controller.

Top module: `keyed_wdog`

## Requirements
- R1: After synchronous reset, `reset_req` is low, the watchdog is disabled and the count does not run until the control register enables it.
- R2: Control register (address 0) fields: bit 7 enables the watchdog, bits 5:4 form the timeout select `sel`, and bit 2 set to 1 bypasses the prescaler. With default parameters the value 0xB4 enables the watchdog with the prescaler bypassed and a timeout of 2^15 clocks.
- R3: With the prescaler bypassed, `reset_req` rises exactly 2^(TO_MIN_LOG2 + TO_STEP_LOG2*sel) clocks after the enabling control write or the last restart. It stays high for one cycle, and the count then restarts from zero.
- R4: With the prescaler in use, the count advances once every 2^PRE_LOG2 clocks, so each timeout is 2^PRE_LOG2 times longer than its bypassed value.
- R5: Writing 0x55 and then 0xAA to the service register (address 1) clears the count and the prescaler, so the next pulse comes one full timeout after the 0xAA write. Repeated 0x55 writes before the 0xAA keep the sequence armed.
- R6: A write of 0xAA to the service register that does not follow an armed 0x55 has no effect on the count.
- R7: A write to the service register of any value other than 0x55 or 0xAA cancels an armed sequence, so a 0xAA after it has no effect.
- R8: Writes to other addresses, including the control register, made between the 0x55 and the 0xAA do not cancel the sequence.
- R9: Only the first control write after reset takes effect. Later control writes are ignored.
- R10: While disabled, the watchdog never raises `reset_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wr_addr | input | ADDR_W | Register address: 0 is control, 1 is service |
| wr_data | input | DATA_W | Write data |
| reset_req | output | 1 | One-cycle reset request on timeout |

## Verification
The assertions assume that the timeout is at least two counts, so two pulses can never fall on adjacent cycles. They also assume that a write is one strobe cycle with its address and data valid in that same cycle. The bench keeps within these limits. It drives each write for exactly one clock, changing the port signals on the falling edge only. A small parameter set keeps every timeout at four counts or more. The bench sweeps all eight combinations of timeout select and prescaler option on this small set, and it checks the 0xB4 value on a second copy that uses the default parameters.

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
  parameter int ADDR_W       = 2,
  parameter int DATA_W       = 8,
  parameter int CTRL_ADDR    = 0,
  parameter int SVC_ADDR     = 1,
  parameter logic [DATA_W-1:0] ARM_KEY  = 8'h55,
  parameter logic [DATA_W-1:0] FIRE_KEY = 8'hAA,
  parameter int PRE_LOG2     = 9,
  parameter int TO_MIN_LOG2  = 9,
  parameter int TO_STEP_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              reset_req
);
  localparam int SEL_W    = 2;
  localparam int EN_BIT   = 7;
  localparam int BYP_BIT  = 2;
  localparam int SEL_LSB  = 4;
  localparam int MAX_LOG2 = TO_MIN_LOG2 + TO_STEP_LOG2 * ((1 << SEL_W) - 1);
  localparam int CNT_W    = MAX_LOG2;
  localparam int LOG_W    = $clog2(MAX_LOG2 + 1);

  logic             ctrl_lock, en_q, byp_q, armed_q;
  logic [SEL_W-1:0] sel_q;
  logic [PRE_LOG2-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q, last;
  logic [CNT_W:0]   span;
  logic [LOG_W-1:0] tlog;

  assign tlog = LOG_W'(TO_MIN_LOG2) + LOG_W'(TO_STEP_LOG2) * LOG_W'(sel_q);
  assign span = (CNT_W+1)'(1) << tlog;
  assign last = span[CNT_W-1:0] - 1'b1;

  wire ctrl_wr = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
  wire svc_wr  = wr_en && (wr_addr == ADDR_W'(SVC_ADDR));
  wire fire    = svc_wr && (wr_data == FIRE_KEY) && armed_q;
  wire tick    = byp_q || (&pre_q);
  wire expire  = en_q && tick && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_lock <= 1'b0;
      en_q      <= 1'b0;
      byp_q     <= 1'b0;
      sel_q     <= '0;
      armed_q   <= 1'b0;
      pre_q     <= '0;
      cnt_q     <= '0;
      reset_req <= 1'b0;
    end else begin
      if (ctrl_wr && !ctrl_lock) begin
        ctrl_lock <= 1'b1;
        en_q      <= wr_data[EN_BIT];
        byp_q     <= wr_data[BYP_BIT];
        sel_q     <= wr_data[SEL_LSB +: SEL_W];
      end
      if (svc_wr)
        armed_q <= (wr_data == ARM_KEY);
      if (fire || !en_q) begin
        pre_q <= '0;
        cnt_q <= '0;
      end else begin
        pre_q <= pre_q + 1'b1;
        if (tick)
          cnt_q <= expire ? '0 : cnt_q + 1'b1;
      end
      reset_req <= expire && !fire;
    end
  end

  AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> !reset_req); // R3
  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last); // R3
  AST_PRESCALE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (en_q && !byp_q && !(&pre_q) && !fire) |=> $stable(cnt_q)); // R4
  AST_KEY_RESTART: assert property (@(posedge clk) disable iff (rst)
    fire |=> (cnt_q == '0 && !reset_req)); // R5
  AST_LONE_FIRE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (svc_wr && wr_data == FIRE_KEY && !armed_q) |=> !armed_q); // R6
  AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (rst)
    ctrl_lock |=> $stable({en_q, byp_q, sel_q})); // R9
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !reset_req); // R10
endmodule

// File: tb/keyed_wdog_bench.sv
module keyed_wdog_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1, wr_s = 1'b0, rr_s;
  logic [1:0] addr_s = '0;
  logic [7:0] data_s = '0;
  logic       rst_d = 1'b1, wr_d = 1'b0, rr_d;
  logic [1:0] addr_d = '0;
  logic [7:0] data_d = '0;

  int cyc = 0;
  int vectors = 0, fails = 0;
  bit d_done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  keyed_wdog u_keyed_wdog (.clk(clk), .rst(rst_d), .wr_en(wr_d), .wr_addr(addr_d),
                           .wr_data(data_d), .reset_req(rr_d));

  keyed_wdog #(.PRE_LOG2(2), .TO_MIN_LOG2(2), .TO_STEP_LOG2(1)) u_small (
    .clk(clk), .rst(rst), .wr_en(wr_s), .wr_addr(addr_s), .wr_data(data_s), .reset_req(rr_s));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_s = 1'b1; addr_s = a; data_s = d;
    @(posedge clk);
    @(negedge clk);
    wr_s = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; wr_s = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic wait_pulse(input int maxc, output int at);
    int n = 0;
    at = -1;
    while (n < maxc && at < 0) begin
      @(negedge clk);
      n++;
      if (rr_s) at = cyc;
    end
  endtask

  task automatic wait_pulse_d(input int maxc, output int at);
    int n = 0;
    at = -1;
    while (n < maxc && at < 0) begin
      @(negedge clk);
      n++;
      if (rr_d) at = cyc;
    end
  endtask

  initial begin
    int t0, p;
    @(negedge clk); rst_d = 1'b0;
    @(negedge clk); wr_d = 1'b1; addr_d = 2'd0; data_d = 8'hB4;
    @(posedge clk); @(negedge clk); wr_d = 1'b0;
    t0 = cyc;
    wait_pulse_d(40000, p);
    check(p - t0 == 32768, "R2 0xB4 first timeout", p - t0, 32768);
    t0 = p;
    wait_pulse_d(40000, p);
    check(p - t0 == 32768, "R2 0xB4 repeat timeout", p - t0, 32768);
    d_done = 1'b1;
  end

  initial begin
    int t0, ta, p, q, lim;
    bit seen;
    do_reset();
    seen = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (rr_s) seen = 1'b1;
    end
    check(!seen, "R1 quiet after reset", seen, 0);

    for (int byp = 0; byp < 2; byp++) begin
      for (int sel = 0; sel < 4; sel++) begin
        lim = (1 << (2 + sel)) * (byp ? 1 : 4);
        do_reset();
        wr(2'd0, 8'(8'h80 | (sel << 4) | (byp << 2)));
        t0 = cyc;
        wait_pulse(300, p);
        check(p - t0 == lim, byp ? "R3 first timeout" : "R4 first prescaled timeout", p - t0, lim);
        @(negedge clk);
        check(!rr_s, "R3 pulse width", rr_s, 0);
        wait_pulse(300, q);
        check(q - p == lim, byp ? "R3 restart period" : "R4 prescaled period", q - p, lim);
      end
    end

    do_reset();
    wr(2'd0, 8'hB4);
    repeat (5) @(negedge clk);
    wr(2'd1, 8'h55);
    wr(2'd1, 8'hAA);
    ta = cyc;
    wait_pulse(100, p);
    check(p - ta == 32, "R5 key sequence restart", p - ta, 32);

    do_reset();
    wr(2'd0, 8'hB4);
    repeat (5) @(negedge clk);
    wr(2'd1, 8'h55);
    wr(2'd1, 8'h55);
    wr(2'd1, 8'hAA);
    ta = cyc;
    wait_pulse(100, p);
    check(p - ta == 32, "R5 repeated arm key", p - ta, 32);

    do_reset();
    wr(2'd0, 8'hB0);
    t0 = cyc;
    repeat (10) @(negedge clk);
    wr(2'd1, 8'h55);
    repeat (20) @(negedge clk);
    wr(2'd1, 8'hAA);
    ta = cyc;
    wait_pulse(300, p);
    check(p - ta == 128, "R5 prescaler cleared by key", p - ta, 128);

    do_reset();
    wr(2'd0, 8'hB4);
    t0 = cyc;
    repeat (5) @(negedge clk);
    wr(2'd1, 8'hAA);
    wait_pulse(100, p);
    check(p - t0 == 32, "R6 lone fire key ignored", p - t0, 32);

    do_reset();
    wr(2'd0, 8'hB4);
    t0 = cyc;
    wr(2'd1, 8'h55);
    wr(2'd1, 8'h12);
    wr(2'd1, 8'hAA);
    wait_pulse(100, p);
    check(p - t0 == 32, "R7 other value disarms", p - t0, 32);

    do_reset();
    wr(2'd0, 8'hB4);
    t0 = cyc;
    repeat (5) @(negedge clk);
    wr(2'd1, 8'h55);
    wr(2'd2, 8'h3C);
    wr(2'd0, 8'h84);
    wr(2'd1, 8'hAA);
    ta = cyc;
    wait_pulse(100, p);
    check(p - ta == 32, "R8 foreign writes keep arm", p - ta, 32);

    do_reset();
    wr(2'd0, 8'h84);
    t0 = cyc;
    wr(2'd0, 8'hB4);
    wait_pulse(100, p);
    check(p - t0 == 4, "R9 second control write ignored", p - t0, 4);
    wait_pulse(100, q);
    check(q - p == 4, "R9 period unchanged", q - p, 4);

    do_reset();
    wr(2'd0, 8'h34);
    wr(2'd0, 8'hB4);
    wait_pulse(300, p);
    check(p < 0, "R10 disabled never pulses", p, -1);

    wait (d_done);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog expired actual=%0d expected=%0d", cyc, 200000);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule